// File: doc/BRIEF.md
# Packed-Pixel Window Statistics Accelerator

This coprocessor sits behind a pair of 32-bit FIFO stream links to a processor. Each input word carries four 8-bit pixels. The processor only pushes words in; all of the arithmetic is done here. For each window, a window-level mode select chooses one of two jobs.

- **Statistics mode.** The block adds up the pixels of one feature window and, in the same pass, adds up their squares.
- **Correlation mode.** The words of two windows arrive interleaved. The block accumulates the scalar product of the two windows, lane by lane.

When a window is complete, its results are queued in a small output FIFO, and the processor reads them back from there. The pixel count of a window is a parameter, with a default of 121 (an 11 by 11 window). In the last word of a window, any pixels past the count are discarded.

A new window may start on the word that follows the final word of the previous one. The square root and the division needed for normalised correlation are done outside this block.

Top module: `winstat_accel`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, and the first accepted word starts a new window.
- R2: Input byte lane i (bits 8i+7..8i) of the k-th word of a window is pixel 4k+i of that window. A window occupies W = ceil(N_PIX/4) words.
- R3: In statistics mode (mode_sel = 0), the W-th accepted word completes the window. Two words are then queued: the pixel sum first, then the sum of squares, each zero-extended to 32 bits.
- R4: Lanes of the final word whose pixel index is N_PIX or above have no effect on any result, whatever their value.
- R5: In correlation mode (mode_sel = 1), 2W words are accepted: even-numbered words (from 0) belong to the first window and odd-numbered words to the second. Matching lanes of each pair are multiplied, and one word is queued, the scalar product.
- R6: mode_sel is sampled only on the first word of a window. Changing it later in the window has no effect.
- R7: The accumulators start from zero for every window, so back-to-back windows give independent results.
- R8: in_ready is 0 whenever the output FIFO has fewer than two free entries. A word presented while in_ready is 0 is not consumed.
- R9: With every pixel at 255 and N_PIX = 121, the results are exact: sum 30855, sum of squares 7868025, and scalar product 7868025.
- R10: Results leave in the order they were produced. While out_valid is 1 and out_ready is 0, out_data holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Block can take an input word |
| in_data | input | 32 | Four packed pixels, lane 0 in the low byte |
| mode_sel | input | 1 | 0 = statistics, 1 = correlation; sampled on a window's first word |
| out_valid | output | 1 | Result word available |
| out_ready | input | 1 | Consumer takes the result word |
| out_data | output | 32 | Result word (sum, sum of squares, or scalar product) |

## Verification
The bench fills the unused lanes of the final word with a non-zero filler byte. A design that did not mask those lanes would return sums that are too large.

It flips mode_sel in the middle of windows. A design that sampled the mode on every word would mix sums and products.

It drives all-255 windows in both modes. A design with accumulators that are too narrow would wrap the sum of squares or the product.

It stacks two statistics windows while the consumer is stalled, then holds a word on the input. A design that ignored the space check would overwrite queued results or take the stalled word into the next window, and the results read back afterwards would then be wrong.

// File: rtl/winstat_pkg.sv
package winstat_pkg;
    localparam int PIX_W  = 8;
    localparam int LANES  = 4;
    localparam int WORD_W = PIX_W * LANES;

    typedef enum logic {
        MODE_STAT = 1'b0,
        MODE_CORR = 1'b1
    } win_mode_e;
endpackage

// File: rtl/winstat_lanes.sv
module winstat_lanes
    import winstat_pkg::*;
#(
    parameter int NL = LANES,
    parameter int PW = PIX_W
) (
    input  logic [NL*PW-1:0]             word_a,
    input  logic [NL*PW-1:0]             word_b,
    input  logic [NL-1:0]                lane_en,
    output logic [PW+$clog2(NL)-1:0]     sum,
    output logic [2*PW+$clog2(NL)-1:0]   sq,
    output logic [2*PW+$clog2(NL)-1:0]   prod
);
    localparam int S_W = PW + $clog2(NL);
    localparam int Q_W = 2 * PW + $clog2(NL);

    logic [PW-1:0]   pa  [NL];
    logic [PW-1:0]   pb  [NL];
    logic [2*PW-1:0] paa [NL];
    logic [2*PW-1:0] pab [NL];

    for (genvar g = 0; g < NL; g++) begin : g_lane
        // lanes past the window end are forced to zero
        assign pa[g]  = lane_en[g] ? word_a[g*PW +: PW] : '0;
        assign pb[g]  = lane_en[g] ? word_b[g*PW +: PW] : '0;
        assign paa[g] = pa[g] * pa[g];
        assign pab[g] = pa[g] * pb[g];
    end

    always_comb begin
        sum  = '0;
        sq   = '0;
        prod = '0;
        for (int i = 0; i < NL; i++) begin
            sum  = sum  + S_W'(pa[i]);
            sq   = sq   + Q_W'(paa[i]);
            prod = prod + Q_W'(pab[i]);
        end
    end
endmodule

// File: rtl/winstat_ofifo.sv
module winstat_ofifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 wr_n,
    input  logic [DW-1:0]              wr_d0,
    input  logic [DW-1:0]              wr_d1,
    input  logic                       rd_en,
    output logic [DW-1:0]              rd_d,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [DW-1:0] mem [DEPTH];

    function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p, input int n);
        int s;
        s = int'(p) + n;
        if (s >= DEPTH) s = s - DEPTH;
        return PTR_W'(s);
    endfunction

    always_comb begin
        st_d     = st_q;
        st_d.wp  = adv(st_q.wp, int'(wr_n));
        st_d.rp  = rd_en ? adv(st_q.rp, 1) : st_q.rp;
        st_d.cnt = st_q.cnt + CNT_W'(wr_n) - CNT_W'(rd_en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_n != 2'd0) mem[st_q.wp]         <= wr_d0;
        if (wr_n == 2'd2) mem[adv(st_q.wp, 1)] <= wr_d1;
    end

    assign rd_d  = mem[st_q.rp];
    assign count = st_q.cnt;

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_n != 2'd0) |-> (int'(st_q.cnt) + int'(wr_n) <= DEPTH + int'(rd_en))); // R8
    AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (st_q.cnt != '0)); // R10
endmodule

// File: rtl/winstat_accel.sv
module winstat_accel
    import winstat_pkg::*;
#(
    parameter int N_PIX      = 121,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic              mode_sel,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data
);
    localparam int WORDS      = (N_PIX + LANES - 1) / LANES;
    localparam int LAST_LANES = N_PIX - LANES * (WORDS - 1);
    localparam logic [LANES-1:0] LAST_MASK = LANES'((1 << LAST_LANES) - 1);
    localparam int ACC_A_W    = $clog2(N_PIX * 255 + 1);
    localparam int ACC_B_W    = $clog2(N_PIX * 65025 + 1);
    localparam int CNT_W      = $clog2(2 * WORDS);
    localparam int FCNT_W     = $clog2(FIFO_DEPTH + 1);
    localparam int L_SUM_W    = PIX_W + $clog2(LANES);
    localparam int L_SQ_W     = 2 * PIX_W + $clog2(LANES);

    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        win_mode_e          mode;
        logic [WORD_W-1:0]  held;
        logic [ACC_A_W-1:0] acc_a;
        logic [ACC_B_W-1:0] acc_b;
    } win_st_t;

    win_st_t st_d, st_q;

    logic               accept;
    win_mode_e          cur_mode;
    logic [CNT_W-1:0]   blk;
    logic [LANES-1:0]   lane_en;
    logic               win_end;
    logic [ACC_A_W-1:0] new_a;
    logic [ACC_B_W-1:0] new_b;
    logic [1:0]         push_n;
    logic [WORD_W-1:0]  push_d0, push_d1;
    logic [L_SUM_W-1:0] l_sum;
    logic [L_SQ_W-1:0]  l_sq, l_prod;
    logic [FCNT_W-1:0]  fcount;
    logic               rd_en;

    winstat_lanes #(.NL(LANES), .PW(PIX_W)) u_lanes (
        .word_a  (in_data),
        .word_b  (st_q.held),
        .lane_en (lane_en),
        .sum     (l_sum),
        .sq      (l_sq),
        .prod    (l_prod)
    );

    // keep two free entries so a statistics result pair always fits
    assign in_ready  = (int'(fcount) <= FIFO_DEPTH - 2);
    assign accept    = in_valid && in_ready;
    assign out_valid = (fcount != '0);
    assign rd_en     = out_valid && out_ready;

    always_comb begin
        st_d     = st_q;
        push_n   = 2'd0;
        push_d0  = '0;
        push_d1  = '0;
        cur_mode = (st_q.cnt == '0) ? win_mode_e'(mode_sel) : st_q.mode;
        blk      = (cur_mode == MODE_CORR) ? (st_q.cnt >> 1) : st_q.cnt;
        lane_en  = (blk == CNT_W'(WORDS - 1)) ? LAST_MASK : '1;
        win_end  = (cur_mode == MODE_CORR) ? (st_q.cnt == CNT_W'(2 * WORDS - 1))
                                           : (st_q.cnt == CNT_W'(WORDS - 1));
        new_a    = st_q.acc_a;
        new_b    = st_q.acc_b;
        if (cur_mode == MODE_STAT) begin
            new_a = st_q.acc_a + ACC_A_W'(l_sum);
            new_b = st_q.acc_b + ACC_B_W'(l_sq);
        end else if (st_q.cnt[0]) begin
            new_b = st_q.acc_b + ACC_B_W'(l_prod);
        end

        if (accept) begin
            st_d.mode = cur_mode;
            if (cur_mode == MODE_CORR && !st_q.cnt[0]) st_d.held = in_data;
            if (win_end) begin
                st_d.cnt   = '0;
                st_d.acc_a = '0;
                st_d.acc_b = '0;
                if (cur_mode == MODE_STAT) begin
                    push_n  = 2'd2;
                    push_d0 = WORD_W'(new_a);
                    push_d1 = WORD_W'(new_b);
                end else begin
                    push_n  = 2'd1;
                    push_d0 = WORD_W'(new_b);
                end
            end else begin
                st_d.cnt   = st_q.cnt + 1'b1;
                st_d.acc_a = new_a;
                st_d.acc_b = new_b;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= MODE_STAT;
        end else begin
            st_q <= st_d;
        end
    end

    winstat_ofifo #(.DEPTH(FIFO_DEPTH), .DW(WORD_W)) u_ofifo (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_n  (push_n),
        .wr_d0 (push_d0),
        .wr_d1 (push_d1),
        .rd_en (rd_en),
        .rd_d  (out_data),
        .count (fcount)
    );

    AST_STALL_NEAR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(fcount) > FIFO_DEPTH - 2) |-> !in_ready); // R8
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R10
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.cnt) < 2 * WORDS); // R5
    AST_MODE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0) |=> $stable(st_q.mode)); // R6
    AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && win_end) |=> (st_q.acc_a == '0 && st_q.acc_b == '0)); // R7
    AST_SUM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.acc_a) <= N_PIX * 255); // R9
endmodule

// File: tb/winstat_accel_tb.sv
module winstat_accel_tb;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int N     = 121;
    localparam int WORDS = (N + 3) / 4;
    localparam int NV    = 7;
    // stimulus table: mode, pixel pattern, pattern constants
    localparam int V_MODE [NV] = '{0, 0, 0, 1, 1, 1, 0};
    localparam int V_KIND [NV] = '{0, 1, 0, 0, 1, 3, 2};
    localparam int V_C1   [NV] = '{0, 7, 255, 255, 5, 11, 90};
    localparam int V_C2   [NV] = '{0, 0, 0, 255, 2, 40, 0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        mode_sel = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    winstat_accel u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .mode_sel  (mode_sel),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pix(input int kind, input int c, input int idx);
        case (kind)
            0:       return c & 255;
            1:       return (idx * c + 3) & 255;
            2:       return (idx ^ c) & 255;
            default: return (idx * idx + c) & 255;
        endcase
    endfunction

    // R2 packing; R4 lanes past N carry a non-zero filler
    function automatic logic [31:0] mk_word(input int kind, input int c, input int k);
        logic [31:0] w;
        for (int l = 0; l < 4; l++) begin
            if (4 * k + l < N) w[8*l +: 8] = 8'(pix(kind, c, 4 * k + l));
            else               w[8*l +: 8] = 8'hAB;
        end
        return w;
    endfunction

    function automatic int e_sum(input int kind, input int c);
        int s = 0;
        for (int i = 0; i < N; i++) s += pix(kind, c, i);
        return s;
    endfunction

    function automatic int e_sq(input int kind, input int c);
        int s = 0;
        for (int i = 0; i < N; i++) s += pix(kind, c, i) * pix(kind, c, i);
        return s;
    endfunction

    function automatic int e_dot(input int kind, input int c1, input int c2);
        int s = 0;
        for (int i = 0; i < N; i++) s += pix(kind, c1, i) * pix(kind, c2, i);
        return s;
    endfunction

    task automatic put_word(input logic [31:0] w, input int m);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        mode_sel = m[0];
        while (!in_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic send_window(input int m, input int kind, input int c1, input int c2,
                               input bit flip);
        for (int k = 0; k < WORDS; k++) begin
            int mm;
            mm = (k == 0 || !flip) ? m : 1 - m;
            put_word(mk_word(kind, c1, k), mm);
            if (m == 1) put_word(mk_word(kind, c2, k), 1 - mm);
        end
        @(negedge clk);
        in_valid = 1'b0;
        mode_sel = 1'b0;
    endtask

    task automatic get_word(output logic [31:0] v);
        int n = 0;
        @(negedge clk);
        while (!out_valid && n < 200) begin
            @(negedge clk);
            n++;
        end
        v = out_data;
        if (!out_valid) begin
            total++;
            bad++;
            $display("FAIL R10: actual=no result expected=result word");
        end
        out_ready = 1'b1;
        @(posedge clk);
        #1 out_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid", 32'(out_valid), 32'd0);
        chk("R1 in_ready", 32'(in_ready), 32'd1);

        // table walk: R2 R3 R4 R5 R9
        for (int v = 0; v < NV; v++) begin
            send_window(V_MODE[v], V_KIND[v], V_C1[v], V_C2[v], 1'b0);
            if (V_MODE[v] == 0) begin
                get_word(r); chk((V_C1[v] == 255) ? "R9 sum" : "R3 sum", r, 32'(e_sum(V_KIND[v], V_C1[v])));
                get_word(r); chk((V_C1[v] == 255) ? "R9 sumsq" : "R3 R4 sumsq", r, 32'(e_sq(V_KIND[v], V_C1[v])));
            end else begin
                get_word(r);
                chk((V_C1[v] == 255) ? "R9 dot" : "R5 R4 dot", r,
                    32'(e_dot(V_KIND[v], V_C1[v], V_C2[v])));
            end
        end

        // R6 mode flipped after the first word
        send_window(0, 1, 13, 0, 1'b1);
        get_word(r); chk("R6 stat sum", r, 32'(e_sum(1, 13)));
        get_word(r); chk("R6 stat sumsq", r, 32'(e_sq(1, 13)));
        send_window(1, 2, 33, 200, 1'b1);
        get_word(r); chk("R6 corr dot", r, 32'(e_dot(2, 33, 200)));

        // R8 / R7 / R10: two windows queued with the consumer stalled
        send_window(0, 3, 1, 0, 1'b0);
        send_window(0, 1, 29, 0, 1'b0);
        @(negedge clk);
        chk("R8 in_ready when full", 32'(in_ready), 32'd0);
        in_valid = 1'b1;
        in_data  = 32'hFFFF_FFFF;
        mode_sel = 1'b1;
        r = out_data;
        repeat (5) @(negedge clk);
        chk("R10 out_data held", out_data, r);
        chk("R8 still stalled", 32'(in_ready), 32'd0);
        in_valid = 1'b0;
        mode_sel = 1'b0;
        get_word(r); chk("R10 order sum0", r, 32'(e_sum(3, 1)));
        get_word(r); chk("R10 order sumsq0", r, 32'(e_sq(3, 1)));
        get_word(r); chk("R7 sum1", r, 32'(e_sum(1, 29)));
        get_word(r); chk("R7 sumsq1", r, 32'(e_sq(1, 29)));

        // R8 the stalled word was not taken into a window
        send_window(0, 2, 5, 0, 1'b0);
        get_word(r); chk("R8 next sum", r, 32'(e_sum(2, 5)));
        get_word(r); chk("R8 next sumsq", r, 32'(e_sq(2, 5)));
        @(negedge clk);
        chk("R10 drained", 32'(out_valid), 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule